// File: doc/BRIEF.md
# Clock Divide Mode Controller

This block holds the power-management control register of a microcontroller core. The register sets how many oscillator clocks make one machine cycle. It also holds the enable for the frequency multiplier and that multiplier's rate select. Software writes the register through a strobe and an 8-bit data word. The block accepts only legal changes of the divide mode and drops illegal ones without any indication. All other fields of the same write are still applied on their own.

The divide modes form a star around the divide-by-4 state, and every mode change must pass through that state. The multiplier mode is refused while the ring oscillator clocks the core, and also while the multiplier is off. Entry into the slowest mode is refused while switchback is armed and a wake source is active. With switchback armed in the slowest mode, the block forces the divide field back to divide-by-4 without software. Three events do this: an acknowledged external interrupt, serial transmit activity, or a falling edge on the serial receive line. The receive line passes through a synchronizer before the edge detector sees it. The oscillator, the multiplier and the interrupt controller are outside the block and appear only as input flags.

Top module: `clkdiv_mode_ctrl`

## Requirements
- R1: The divide field never holds the reserved code 01. A write that requests 01 leaves the divide field unchanged.
- R2: Divide codes are 00 = multiplier (1 or 2 clocks), 10 = divide-by-4 and 11 = divide-by-1024. A written divide code is taken only if the current or the requested code is 10. Any other change is ignored.
- R3: A write that requests code 00 is ignored while the ring-oscillator flag is high or the multiplier enable bit is clear.
- R4: A write that requests code 11 is ignored while the stored switchback enable bit is 1 and any wake source is active. The wake sources are a pending external interrupt, serial transmit activity, and a detected receive falling edge.
- R5: While switchback is enabled and the divide field is 11, any of three events sets the divide field to 10 at the next clock edge: an interrupt acknowledge, serial transmit activity, or a receive falling edge. A receive falling edge is seen RX_SYNC_STAGES+1 edges after the line falls. With switchback disabled these events have no effect.
- R6: The multiplier enable bit (bit 4) takes its written value only when the divide field is 10 and the mode-lock flag is low. Otherwise it keeps its value.
- R7: On every write, the switchback enable (bit 5), the rate select (bit 3, 1 = one clock, 0 = two clocks) and the address-latch-off bit (bit 2) take the written value. This happens even when the divide change in the same write is rejected.
- R8: After reset the read value is 8'h83: divide 10 and all other writable bits 0. Bits 1:0 always read 11, whatever is written.
- R9: A switchback in the same cycle as a write forces the divide field to 10. The other fields of that write are still applied.
- R10: The read value is {divide[7:6], switchback[5], multiplier enable[4], rate[3], address-latch-off[2], 2'b11}. The mode outputs equal those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| ring_osc_active | input | 1 | Core runs from the ring oscillator |
| mode_lock | input | 1 | Blocks changes of the multiplier enable |
| ext_irq_pend | input | 1 | An enabled external interrupt is requesting |
| ext_irq_ack | input | 1 | External interrupt acknowledged (vector jump) |
| ser_tx_active | input | 1 | Serial transmitter busy |
| ser_rx_line | input | 1 | Serial receive line, asynchronous, idle high |
| div_mode | output | 2 | Current divide code |
| swb_en | output | 1 | Switchback enable |
| mult_en | output | 1 | Frequency multiplier enable |
| rate_1x | output | 1 | Multiplier rate select |
| addr_latch_off | output | 1 | Address-latch-off control |
| rd_data | output | 8 | Register read value |

## Verification
The bench targets the direct jumps 00 to 11 and 11 to 00. A design that allowed them would show a change of the divide field. It also tries to enter the multiplier mode with the ring oscillator running or the multiplier disabled, and a broken guard would let the field reach 00. It tries to enter divide-by-1024 with switchback armed while a wake source is active, checks that writes to the multiplier enable under lock or outside divide-by-4 have no effect, and checks the receive-edge switchback at its exact cycle, where a missing or extra synchronizer stage shifts the change by one edge. A write that arrives together with a switchback checks that the hardware override wins for the divide field only. A seeded random phase then compares the read value each cycle with a bench model.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    DIV_MULT = 2'b00,
    DIV_RSVD = 2'b01,
    DIV_4    = 2'b10,
    DIV_1024 = 2'b11
  } div_mode_e;

  localparam int REG_W    = 8;
  localparam int DIV_LSB  = 6;
  localparam int SWB_BIT  = 5;
  localparam int MULT_BIT = 4;
  localparam int RATE_BIT = 3;
  localparam int ALE_BIT  = 2;
  localparam logic [1:0] RO_ONES = 2'b11;

  // Legality of a requested divide change, given the blocking conditions.
  function automatic logic move_ok(div_mode_e cur, div_mode_e req,
                                   logic ring_on, logic mult_on, logic slow_block);
    logic ok;
    ok = (req != cur) && (req != DIV_RSVD) && ((cur == DIV_4) || (req == DIV_4));
    if (req == DIV_MULT && (ring_on || !mult_on)) ok = 1'b0;
    if (req == DIV_1024 && slow_block) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(div_mode_e d, logic swb, logic mult,
                                                logic rate, logic ale);
    return {d, swb, mult, rate, ale, RO_ONES};
  endfunction
endpackage

// File: rtl/clkdiv_sb_detect.sv
module clkdiv_sb_detect #(
  parameter int RX_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_rx_line,
  input  logic ext_irq_pend,
  input  logic ext_irq_ack,
  input  logic ser_tx_active,
  output logic rx_fall,
  output logic sb_trigger,
  output logic src_active
);
  localparam int LAST = RX_SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  generate
    for (genvar s = 0; s < RX_SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= ser_rx_line;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[LAST];

  assign rx_fall    = prev_q & ~sync_q[LAST];
  assign sb_trigger = ext_irq_ack | ser_tx_active | rx_fall;
  assign src_active = ext_irq_pend | ser_tx_active | rx_fall;

  // R5: a detected falling edge is a single-cycle event
  a_r5_rx_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall |=> !rx_fall);
endmodule

// File: rtl/clkdiv_div_guard.sv
module clkdiv_div_guard
  import clkdiv_pkg::*;
(
  input  div_mode_e cur_div,
  input  logic [1:0] req_bits,
  input  logic      wr_en,
  input  logic      ring_osc_active,
  input  logic      mult_on,
  input  logic      swb_on,
  input  logic      src_active,
  input  logic      sb_fire,
  output div_mode_e next_div,
  output logic      wr_accept
);
  div_mode_e req;
  logic      slow_block;

  always_comb begin
    req        = div_mode_e'(req_bits);
    slow_block = swb_on & src_active;
    wr_accept  = wr_en & move_ok(cur_div, req, ring_osc_active, mult_on, slow_block);
    if (sb_fire)        next_div = DIV_4;
    else if (wr_accept) next_div = req;
    else                next_div = cur_div;
  end
endmodule

// File: rtl/clkdiv_mult_guard.sv
module clkdiv_mult_guard
  import clkdiv_pkg::*;
(
  input  div_mode_e cur_div,
  input  logic      wr_en,
  input  logic      mode_lock,
  input  logic      wr_bit,
  input  logic      cur_mult,
  output logic      next_mult,
  output logic      mult_wr_ok
);
  always_comb begin
    mult_wr_ok = wr_en & (cur_div == DIV_4) & ~mode_lock;
    next_mult  = mult_wr_ok ? wr_bit : cur_mult;
  end
endmodule

// File: rtl/clkdiv_mode_ctrl.sv
module clkdiv_mode_ctrl
  import clkdiv_pkg::*;
#(
  parameter int RX_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ring_osc_active,
  input  logic       mode_lock,
  input  logic       ext_irq_pend,
  input  logic       ext_irq_ack,
  input  logic       ser_tx_active,
  input  logic       ser_rx_line,
  output logic [1:0] div_mode,
  output logic       swb_en,
  output logic       mult_en,
  output logic       rate_1x,
  output logic       addr_latch_off,
  output logic [7:0] rd_data
);
  div_mode_e div_q, div_d;
  logic      swb_q, mult_q, mult_d, rate_q, ale_q;
  logic      rx_fall, sb_trigger, src_active, sb_fire;
  logic      div_wr_accept, mult_wr_ok;

  clkdiv_sb_detect #(.RX_SYNC_STAGES(RX_SYNC_STAGES)) u_sb (
    .clk(clk), .rst_n(rst_n), .ser_rx_line(ser_rx_line),
    .ext_irq_pend(ext_irq_pend), .ext_irq_ack(ext_irq_ack),
    .ser_tx_active(ser_tx_active), .rx_fall(rx_fall),
    .sb_trigger(sb_trigger), .src_active(src_active)
  );

  assign sb_fire = swb_q & (div_q == DIV_1024) & sb_trigger;

  clkdiv_div_guard u_div (
    .cur_div(div_q), .req_bits(wr_data[DIV_LSB+1:DIV_LSB]), .wr_en(wr_en),
    .ring_osc_active(ring_osc_active), .mult_on(mult_q), .swb_on(swb_q),
    .src_active(src_active), .sb_fire(sb_fire),
    .next_div(div_d), .wr_accept(div_wr_accept)
  );

  clkdiv_mult_guard u_mult (
    .cur_div(div_q), .wr_en(wr_en), .mode_lock(mode_lock),
    .wr_bit(wr_data[MULT_BIT]), .cur_mult(mult_q),
    .next_mult(mult_d), .mult_wr_ok(mult_wr_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_4;
      swb_q  <= 1'b0;
      mult_q <= 1'b0;
      rate_q <= 1'b0;
      ale_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      mult_q <= mult_d;
      if (wr_en) begin
        swb_q  <= wr_data[SWB_BIT];
        rate_q <= wr_data[RATE_BIT];
        ale_q  <= wr_data[ALE_BIT];
      end
    end
  end

  assign div_mode       = div_q;
  assign swb_en         = swb_q;
  assign mult_en        = mult_q;
  assign rate_1x        = rate_q;
  assign addr_latch_off = ale_q;
  assign rd_data        = pack_reg(div_q, swb_q, mult_q, rate_q, ale_q);

  // R1: the reserved code is never held
  a_r1_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    div_mode != 2'b01);
  // R2: every change of the divide field touches divide-by-4
  a_r2_star_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode != $past(div_mode)) |-> (div_mode == 2'b10 || $past(div_mode) == 2'b10));
  // R2: the divide field only moves on a write or a switchback
  a_r2_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode != $past(div_mode)) |-> ($past(wr_en) || $past(sb_trigger)));
  // R3: multiplier mode is entered only off the ring oscillator with the multiplier on
  a_r3_mult_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode == 2'b00 && $past(div_mode) != 2'b00) |-> ($past(!ring_osc_active) && $past(mult_en)));
  // R4: slow mode is not entered by a write while armed and a source is active
  a_r4_slow_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode == 2'b11 && $past(div_mode) != 2'b11) |-> !($past(swb_en) && $past(src_active)));
  // R5, R9: armed switchback always lands in divide-by-4
  a_r5_switchback: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_en && div_mode == 2'b11 && sb_trigger) |=> div_mode == 2'b10);
  // R6: the multiplier enable changes only through an allowed write
  a_r6_mult_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_en != $past(mult_en)) |-> ($past(wr_en) && $past(div_mode) == 2'b10 && !$past(mode_lock)));
  // R7: free fields follow the write data
  a_r7_free_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (swb_en == $past(wr_data[5]) && rate_1x == $past(wr_data[3])
               && addr_latch_off == $past(wr_data[2])));
  // R8: read-only bits stay 11 whatever is written
  a_r8_ro_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1:0] != 2'b11) |=> rd_data[1:0] == 2'b11);
  // R6: a permitted multiplier write and an accepted divide write agree with the data
  a_r6_mult_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_wr_ok || div_wr_accept) |=> (mult_en == $past(mult_wr_ok ? wr_data[4] : mult_en)));
endmodule

// File: tb/tb_clkdiv_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clkdiv_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ring_osc_active = 1'b0, mode_lock = 1'b0;
  logic       ext_irq_pend = 1'b0, ext_irq_ack = 1'b0;
  logic       ser_tx_active = 1'b0, ser_rx_line = 1'b1;
  logic [1:0] div_mode;
  logic       swb_en, mult_en, rate_1x, addr_latch_off;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkdiv_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ring_osc_active(ring_osc_active), .mode_lock(mode_lock),
    .ext_irq_pend(ext_irq_pend), .ext_irq_ack(ext_irq_ack),
    .ser_tx_active(ser_tx_active), .ser_rx_line(ser_rx_line),
    .div_mode(div_mode), .swb_en(swb_en), .mult_en(mult_en),
    .rate_1x(rate_1x), .addr_latch_off(addr_latch_off), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of one clock edge, written from the requirements.
  function automatic logic [7:0] model_next(logic [7:0] m, logic wr, logic [7:0] d,
      logic ring, logic lock, logic pend, logic ack, logic tx);
    logic [7:0] r;
    logic [1:0] cur, req;
    logic legal;
    r = m; cur = m[7:6]; req = d[7:6];
    if (wr) begin
      r[5] = d[5]; r[3] = d[3]; r[2] = d[2];
      if (cur == 2'b10 && !lock) r[4] = d[4];
      legal = (req != cur) && (req != 2'b01) && (cur == 2'b10 || req == 2'b10);
      if (req == 2'b00 && (ring || !m[4])) legal = 1'b0;
      if (req == 2'b11 && m[5] && (pend || tx)) legal = 1'b0;
      if (legal) r[7:6] = req;
    end
    if (m[5] && cur == 2'b11 && (ack || tx)) r[7:6] = 2'b10;
    return r;
  endfunction

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ext_irq_ack = 1'b1;
    @(negedge clk); ext_irq_ack = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); ser_tx_active = 1'b1;
    @(negedge clk); ser_tx_active = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset value", rd_data, 8'h83);
    chk("R10 field outputs", {div_mode, swb_en, mult_en, rate_1x, addr_latch_off, 2'b11}, rd_data);

    wr(8'h00);               chk("R3 multiplier mode while multiplier off", rd_data, 8'h83);
    wr(8'h90);               chk("R6 multiplier enable in divide-by-4", rd_data, 8'h93);
    ring_osc_active = 1'b1;
    wr(8'h18);               chk("R3 ring oscillator blocks, R7 rate still set", rd_data, 8'h9B);
    ring_osc_active = 1'b0;
    wr(8'h18);               chk("R3 multiplier mode entered", rd_data, 8'h1B);
    wr(8'hD8);               chk("R2 direct 00 to 11 ignored", rd_data, 8'h1B);
    wr(8'h08);               chk("R6 multiplier enable held outside divide-by-4", rd_data, 8'h1B);
    wr(8'h98);               chk("R2 back to divide-by-4", rd_data, 8'h9B);
    wr(8'h5B);               chk("R1 reserved code ignored, R8 low bits", rd_data, 8'h9B);
    mode_lock = 1'b1;
    wr(8'h88);               chk("R6 lock blocks multiplier enable", rd_data, 8'h9B);
    mode_lock = 1'b0;
    wr(8'hB8);               chk("R7 switchback enable set", rd_data, 8'hBB);
    ext_irq_pend = 1'b1;
    wr(8'hF8);               chk("R4 slow entry blocked by pending source", rd_data, 8'hBB);
    ext_irq_pend = 1'b0;
    wr(8'hF8);               chk("R4 slow entry allowed", rd_data, 8'hFB);
    wr(8'hE8);               chk("R6 multiplier enable held in 1024", rd_data, 8'hFB);
    pulse_ack();             chk("R5 interrupt acknowledge switchback", rd_data, 8'hBB);
    wr(8'hF8);
    pulse_tx();              chk("R5 transmit switchback", rd_data, 8'hBB);
    wr(8'hF8);
    @(negedge clk); ser_rx_line = 1'b0;
    @(negedge clk);
    @(negedge clk);          chk("R5 receive edge not yet seen", rd_data, 8'hFB);
    @(negedge clk);          chk("R5 receive edge switchback", rd_data, 8'hBB);
    ser_rx_line = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'hD8);               chk("R7 switchback disabled in 1024", rd_data, 8'hDB);
    pulse_ack();             chk("R5 no switchback when disabled", rd_data, 8'hDB);
    pulse_tx();              chk("R5 transmit ignored when disabled", rd_data, 8'hDB);
    wr(8'hF8);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h1C; ext_irq_ack = 1'b1;
    @(negedge clk); wr_en = 1'b0; ext_irq_ack = 1'b0;
    chk("R9 switchback wins over same-cycle write", rd_data, 8'h9F);

    // Random phase against the model, from a fresh reset.
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m = 8'h83;
    for (int i = 0; i < 2000; i++) begin
      wr_en           = ($urandom % 2) == 0;
      wr_data         = 8'($urandom);
      ring_osc_active = ($urandom % 4) == 0;
      mode_lock       = ($urandom % 4) == 0;
      ext_irq_pend    = ($urandom % 7) == 0;
      ext_irq_ack     = ($urandom % 10) == 0;
      ser_tx_active   = ($urandom % 10) == 0;
      m = model_next(m, wr_en, wr_data, ring_osc_active, mode_lock,
                     ext_irq_pend, ext_irq_ack, ser_tx_active);
      @(negedge clk);
      chk("R1-model R2 R3 R4 R5 R6 R7 random", rd_data, m);
    end
    wr_en = 1'b0; ext_irq_ack = 1'b0; ser_tx_active = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule